// File: doc/BRIEF.md
# Serial register write port with shadowed update

This block is the receiving end of a three-wire control link for a frequency synthesizer. Each transaction starts with a command byte that selects a register. A fixed number of data bytes for that register follows, most significant bit first. Completed registers are held in a shadow bank. They reach the outputs that drive the synthesizer only when the update input rises.

Several registers can be written one after another while chip select stays low. A special command opens the waveform RAM. After it, every four bytes form one 32-bit word, written at falling addresses, until chip select rises.

The serial pins and the update pin are brought into the system clock domain through equal-length synchronizers. The system clock is expected to run at least six times faster than the serial clock.

Top module: `synth_ctrl_port`

## Requirements
- R1: After reset every active register output is zero and `ram_we_o` is low.
- R2: A bit is taken on each rising edge of `sclk_i` while `csn_i` is low, most significant bit first, and eight bits form one byte. In a command byte, bits 6..0 hold the address and bit 7 must be zero.
- R3: The number of data bytes depends on the address: 0x00 (`ctl1_o`) takes 4, 0x01 (`ctl2_o`) 3, 0x02 (`amp_o`) 2, 0x04 (`ftw0_o`) 4, 0x05 (`phase_o`) 2, 0x06 (`ftw1_o`) 4, 0x07 (`sweep_dn_o`) 5 and 0x08 (`sweep_up_o`) 5. The first data byte is the most significant byte of the value.
- R4: An active output changes only in response to a rising edge of `update_i`. That edge copies every shadow register to the outputs.
- R5: Once a register's last byte is received, the next byte in the same chip-select-low period is decoded as a new command.
- R6: A rising `csn_i` discards a partial byte and a partially received register, and leaves their shadow contents unchanged. The next low period starts with a command byte.
- R7: A command byte with bit 7 set, or with an address not listed in R3 or R8, is ignored together with every following byte until `csn_i` rises.
- R8: Address 0x0B is accepted only while active `ctl1_o` bit 31 (RAM enable) is 1. The start address is bits 9..0 of the active word at 0x07 when `profile_i` is 0, or at 0x08 when it is 1. Words are then written at that address, then the address minus 1, and so on, wrapping from 0 to the top of the RAM.
- R9: Address 0x0B sent while RAM enable is 0 produces no RAM write, and its following bytes are ignored as in R7.
- R10: An `update_i` rise that arrives on the same system clock edge as the `sclk_i` rise carrying a register's last bit includes that register's new value.
- R11: Each RAM word is four bytes, most significant first. It is written with a single-cycle `ram_we_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data |
| update_i | input | 1 | Shadow-to-active transfer strobe, rising edge |
| profile_i | input | 1 | Selects which segment word gives the RAM start address |
| ctl1_o | output | 32 | Active control word 1 (bit 31 = RAM enable) |
| ctl2_o | output | 24 | Active control word 2 |
| amp_o | output | 16 | Active amplitude scale |
| ftw0_o | output | 32 | Active tuning word 0 |
| phase_o | output | 16 | Active phase offset |
| ftw1_o | output | 32 | Active tuning word 1 |
| sweep_dn_o | output | 40 | Active falling sweep word / segment 0 word |
| sweep_up_o | output | 40 | Active rising sweep word / segment 1 word |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | RAM_AW | RAM write address |
| ram_data_o | output | 32 | RAM write data |

## Verification
Two events can land on the same clock: the commit of a fully received register into its shadow, and the shadow-to-active transfer. The bench raises `update_i` in the very time step in which it raises `sclk_i` for the final bit of a phase offset write. Both inputs pass through synchronizers of equal length, so the two events meet at the bank together. The bench model expects the new value to appear on `phase_o` without any second update pulse, and it compares every active output on every clock once the transfer has settled.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int NREG    = 8;
  localparam int REG_W   = 40;
  localparam int IDX_W   = $clog2(NREG);
  localparam int WORD_W  = 32;
  localparam logic [6:0] RAM_CMD = 7'h0B;

  typedef enum logic [1:0] {ST_CMD, ST_DATA, ST_RAM, ST_DROP} seq_st_e;

  typedef struct packed {
    logic             hit;
    logic             ram;
    logic [IDX_W-1:0] idx;
    logic [2:0]       nbytes;
  } reg_info_t;

  function automatic reg_info_t decode_addr(logic [6:0] a);
    reg_info_t r;
    r = '0;
    r.hit = 1'b1;
    case (a)
      7'h00: begin r.idx = 3'd0; r.nbytes = 3'd4; end
      7'h01: begin r.idx = 3'd1; r.nbytes = 3'd3; end
      7'h02: begin r.idx = 3'd2; r.nbytes = 3'd2; end
      7'h04: begin r.idx = 3'd3; r.nbytes = 3'd4; end
      7'h05: begin r.idx = 3'd4; r.nbytes = 3'd2; end
      7'h06: begin r.idx = 3'd5; r.nbytes = 3'd4; end
      7'h07: begin r.idx = 3'd6; r.nbytes = 3'd5; end
      7'h08: begin r.idx = 3'd7; r.nbytes = 3'd5; end
      RAM_CMD: r.ram = 1'b1;
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/scp_shift.sv
module scp_shift #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       csn_i,
  input  logic       sclk_i,
  input  logic       sdata_i,
  output logic       cs_idle_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o
);
  logic [SYNC_STAGES-1:0] csn_q, sclk_q, sdat_q;
  logic       sclk_last;
  logic [2:0] bit_cnt;
  logic [6:0] sh;
  logic       csn_s, sclk_s, sdat_s, rise;

  assign csn_s  = csn_q[SYNC_STAGES-1];
  assign sclk_s = sclk_q[SYNC_STAGES-1];
  assign sdat_s = sdat_q[SYNC_STAGES-1];
  assign rise   = sclk_s & ~sclk_last;
  assign cs_idle_o = csn_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csn_q  <= '1;
      sclk_q <= '0;
      sdat_q <= '0;
    end else begin
      csn_q  <= {csn_q[SYNC_STAGES-2:0], csn_i};
      sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk_i};
      sdat_q <= {sdat_q[SYNC_STAGES-2:0], sdata_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_last  <= 1'b0;
      bit_cnt    <= '0;
      sh         <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      sclk_last  <= sclk_s;
      byte_vld_o <= 1'b0;
      if (csn_s) begin
        bit_cnt <= '0;
      end else if (rise) begin
        sh      <= {sh[5:0], sdat_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_o     <= {sh, sdat_s};
          byte_vld_o <= 1'b1;
        end
      end
    end
  end

  // R6
  idle_no_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |=> !byte_vld_o);
endmodule

// File: rtl/scp_seq.sv
module scp_seq
  import scp_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_idle_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              ram_en_i,
  input  logic              profile_i,
  input  logic [RAM_AW-1:0] seg0_end_i,
  input  logic [RAM_AW-1:0] seg1_end_i,
  output logic              wr_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [REG_W-1:0]  wr_data_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [WORD_W-1:0] ram_data_o
);
  seq_st_e           state;
  logic [2:0]        left;
  logic [31:0]       acc;
  logic [IDX_W-1:0]  idx_q;
  logic [RAM_AW-1:0] ram_ptr;
  logic [1:0]        ram_cnt;
  reg_info_t         info;

  assign info = decode_addr(byte_i[6:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_CMD;
      left       <= '0;
      acc        <= '0;
      idx_q      <= '0;
      ram_ptr    <= '0;
      ram_cnt    <= '0;
      wr_o       <= 1'b0;
      wr_idx_o   <= '0;
      wr_data_o  <= '0;
      ram_we_o   <= 1'b0;
      ram_addr_o <= '0;
      ram_data_o <= '0;
    end else begin
      wr_o     <= 1'b0;
      ram_we_o <= 1'b0;
      if (cs_idle_i) begin
        state <= ST_CMD;
      end else if (byte_vld_i) begin
        case (state)
          ST_CMD: begin
            acc <= '0;
            if (byte_i[7] || !info.hit) begin
              state <= ST_DROP;
            end else if (info.ram) begin
              if (ram_en_i) begin
                state   <= ST_RAM;
                ram_cnt <= '0;
                ram_ptr <= profile_i ? seg1_end_i : seg0_end_i;
              end else begin
                state <= ST_DROP;
              end
            end else begin
              state <= ST_DATA;
              left  <= info.nbytes;
              idx_q <= info.idx;
            end
          end
          ST_DATA: begin
            acc <= {acc[23:0], byte_i};
            if (left == 3'd1) begin
              wr_o      <= 1'b1;
              wr_idx_o  <= idx_q;
              wr_data_o <= {acc, byte_i};
              state     <= ST_CMD;
            end else begin
              left <= left - 3'd1;
            end
          end
          ST_RAM: begin
            acc     <= {acc[23:0], byte_i};
            ram_cnt <= ram_cnt + 2'd1;
            if (ram_cnt == 2'd3) begin
              ram_we_o   <= 1'b1;
              ram_addr_o <= ram_ptr;
              ram_data_o <= {acc[23:0], byte_i};
              ram_ptr    <= ram_ptr - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7
  drop_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DROP) |=> (!wr_o && !ram_we_o));
  // R11
  ram_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o);
  // R3
  commit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ($past(state) == ST_DATA));
  // R8
  ram_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ($past(state) == ST_RAM));
endmodule

// File: rtl/scp_bank.sv
module scp_bank
  import scp_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [REG_W-1:0]           wr_data_i,
  input  logic                       upd_i,
  output logic [NREG-1:0][REG_W-1:0] act_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [REG_W-1:0] shadow;
    logic             hit;
    assign hit = wr_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow   <= '0;
        act_o[g] <= '0;
      end else begin
        if (hit) shadow <= wr_data_i;
        // a commit landing with the transfer is passed straight through
        if (upd_i) act_o[g] <= hit ? wr_data_i : shadow;
      end
    end
  end

  // R4
  hold_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(act_o));
endmodule

// File: rtl/synth_ctrl_port.sv
module synth_ctrl_port
  import scp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RAM_AW      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csn_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              update_i,
  input  logic              profile_i,
  output logic [31:0]       ctl1_o,
  output logic [23:0]       ctl2_o,
  output logic [15:0]       amp_o,
  output logic [31:0]       ftw0_o,
  output logic [15:0]       phase_o,
  output logic [31:0]       ftw1_o,
  output logic [39:0]       sweep_dn_o,
  output logic [39:0]       sweep_up_o,
  output logic              ram_we_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic [WORD_W-1:0] ram_data_o
);
  // shift register -> byte register -> commit: update is delayed to match
  localparam int UPD_DLY = 2;

  logic                       cs_idle, byte_vld;
  logic [7:0]                 byte_q;
  logic                       wr;
  logic [IDX_W-1:0]           wr_idx;
  logic [REG_W-1:0]           wr_data;
  logic [NREG-1:0][REG_W-1:0] act;
  logic [SYNC_STAGES-1:0]     upd_q;
  logic                       upd_last;
  logic [UPD_DLY-1:0]         upd_dly;
  logic                       upd_s;

  assign upd_s = upd_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q    <= '0;
      upd_last <= 1'b0;
      upd_dly  <= '0;
    end else begin
      upd_q    <= {upd_q[SYNC_STAGES-2:0], update_i};
      upd_last <= upd_s;
      upd_dly  <= {upd_dly[UPD_DLY-2:0], upd_s & ~upd_last};
    end
  end

  scp_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csn_i      (csn_i),
    .sclk_i     (sclk_i),
    .sdata_i    (sdata_i),
    .cs_idle_o  (cs_idle),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_q)
  );

  scp_seq #(.RAM_AW(RAM_AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_idle_i  (cs_idle),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_q),
    .ram_en_i   (act[0][31]),
    .profile_i  (profile_i),
    .seg0_end_i (act[6][RAM_AW-1:0]),
    .seg1_end_i (act[7][RAM_AW-1:0]),
    .wr_o       (wr),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o),
    .ram_data_o (ram_data_o)
  );

  scp_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .upd_i     (upd_dly[UPD_DLY-1]),
    .act_o     (act)
  );

  assign ctl1_o     = act[0][31:0];
  assign ctl2_o     = act[1][23:0];
  assign amp_o      = act[2][15:0];
  assign ftw0_o     = act[3][31:0];
  assign phase_o    = act[4][15:0];
  assign ftw1_o     = act[5][31:0];
  assign sweep_dn_o = act[6];
  assign sweep_up_o = act[7];

  logic unused_hi;
  assign unused_hi = ^{act[0][39:32], act[1][39:24], act[2][39:16], act[3][39:32],
                       act[4][39:16], act[5][39:32]};

  // R10
  commit_meets_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && upd_dly[UPD_DLY-1] && wr_idx == 3'd4) |=> (phase_o == $past(wr_data[15:0])));
endmodule

// File: tb/synth_ctrl_port_tb.sv
`timescale 1ns/1ps
module synth_ctrl_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, sdata = 1'b0, upd = 1'b0, prof = 1'b0;
  logic [31:0] ctl1, ftw0, ftw1, ram_data;
  logic [23:0] ctl2;
  logic [15:0] amp, phase;
  logic [39:0] swdn, swup;
  logic        ram_we;
  logic [9:0]  ram_addr;

  always #2.5 clk = ~clk;

  synth_ctrl_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sclk_i(sclk), .sdata_i(sdata),
    .update_i(upd), .profile_i(prof), .ctl1_o(ctl1), .ctl2_o(ctl2), .amp_o(amp),
    .ftw0_o(ftw0), .phase_o(phase), .ftw1_o(ftw1), .sweep_dn_o(swdn),
    .sweep_up_o(swup), .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_data_o(ram_data)
  );

  int n_chk = 0, n_fail = 0, settle = 0, ram_cnt = 0;
  bit done = 0;
  logic [39:0] exp_sh [8];
  logic [39:0] exp_act[8];
  logic [41:0] ram_q[$];

  initial for (int i = 0; i < 8; i++) begin exp_sh[i] = '0; exp_act[i] = '0; end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbytes(int a);
    case (a)
      0: return 4; 1: return 3; 2: return 2; 4: return 4;
      5: return 2; 6: return 4; 7: return 5; 8: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int slot(int a);
    return (a < 3) ? a : a - 1;
  endfunction

  // reference comparison on every clock, away from the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (ram_we) begin
        ram_cnt++;
        if (ram_q.size() == 0) chk("R8 unexpected RAM write", 1, 0);
        else begin
          logic [41:0] e;
          e = ram_q.pop_front();
          chk("R8 RAM address", 64'(ram_addr), 64'(e[41:32]));
          chk("R11 RAM data", 64'(ram_data), 64'(e[31:0]));
        end
      end
      if (settle > 0) settle--;
      else begin
        chk("R4 ctl1", 64'(ctl1), 64'(exp_act[0][31:0]));
        chk("R4 ctl2", 64'(ctl2), 64'(exp_act[1][23:0]));
        chk("R4 amp", 64'(amp), 64'(exp_act[2][15:0]));
        chk("R4 ftw0", 64'(ftw0), 64'(exp_act[3][31:0]));
        chk("R4 phase", 64'(phase), 64'(exp_act[4][15:0]));
        chk("R4 ftw1", 64'(ftw1), 64'(exp_act[5][31:0]));
        chk("R4 sweep_dn", 64'(swdn), 64'(exp_act[6]));
        chk("R4 sweep_up", 64'(swup), 64'(exp_act[7]));
      end
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic put_bit(logic b, bit upd_now);
    sdata = b; tick(3);
    sclk = 1'b1;
    if (upd_now) begin settle = 12; exp_act = exp_sh; upd = 1'b1; end
    tick(3); sclk = 1'b0;
  endtask

  task automatic put_byte(logic [7:0] v, bit upd_last);
    for (int i = 7; i >= 0; i--) put_bit(v[i], upd_last && i == 0);
  endtask

  task automatic cs_on;  csn = 1'b0; tick(4); endtask
  task automatic cs_off; tick(4); csn = 1'b1; upd = 1'b0; tick(8); endtask

  task automatic wr_reg(int a, logic [39:0] v, bit upd_end = 0);
    int n;
    n = nbytes(a);
    put_byte(8'(a), 0);
    if (upd_end) exp_sh[slot(a)] = v;
    for (int k = n - 1; k >= 0; k--) put_byte(v[8*k +: 8], upd_end && k == 0);
    exp_sh[slot(a)] = v;
  endtask

  task automatic pulse_upd;
    settle = 12; exp_act = exp_sh; upd = 1'b1; tick(4); upd = 1'b0; tick(12);
  endtask

  task automatic ram_stream(bit p, int nw, logic [31:0] base);
    logic [9:0] a;
    prof = p; tick(4);
    a = p ? exp_act[7][9:0] : exp_act[6][9:0];
    cs_on;
    put_byte(8'h0B, 0);
    for (int w = 0; w < nw; w++) begin
      logic [31:0] d;
      d = base + 32'(w) * 32'h01010101;
      if (exp_act[0][31]) ram_q.push_back({a, d});
      a = a - 10'd1;
      for (int k = 3; k >= 0; k--) put_byte(d[8*k +: 8], 0);
    end
    cs_off;
    tick(10);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    int rc;
    tick(5); rst_n = 1'b1; tick(4);
    // R1 reset state
    chk("R1 ctl1", 64'(ctl1), 0); chk("R1 sweep_up", 64'(swup), 0);
    chk("R1 ram_we", 64'(ram_we), 0);

    // R2/R4: single register, held until update
    cs_on; wr_reg(4, 40'h00A3D70A); cs_off;
    tick(20);
    chk("R4 ftw0 before update", 64'(ftw0), 0);
    pulse_upd;
    chk("R2 ftw0 msb first", 64'(ftw0), 64'h00A3D70A);

    // R5/R3: back-to-back registers in one select period
    cs_on;
    wr_reg(2, 40'h3FFF); wr_reg(1, 40'h0008A4); wr_reg(5, 40'h2000);
    wr_reg(6, 40'h016872B0); wr_reg(7, 40'h10_0000_0010); wr_reg(8, 40'hA5_1234_5678);
    cs_off;
    pulse_upd;
    chk("R5 amp", 64'(amp), 64'h3FFF);
    chk("R3 ctl2 3 bytes", 64'(ctl2), 64'h0008A4);
    chk("R3 sweep_up 5 bytes", 64'(swup), 64'hA512345678);
    chk("R5 phase", 64'(phase), 64'h2000);

    // R6: partial register and partial byte dropped
    cs_on; put_byte(8'h05, 0); put_byte(8'h12, 0);
    put_bit(1, 0); put_bit(0, 0); put_bit(1, 0); cs_off;
    cs_on; put_bit(0, 0); put_bit(0, 0); put_bit(0, 0); cs_off;
    cs_on; wr_reg(2, 40'h0155); cs_off;
    pulse_upd;
    chk("R6 phase kept", 64'(phase), 64'h2000);
    chk("R6 fresh command", 64'(amp), 64'h0155);

    // R7: bit 7 set and unknown address, with trailing data
    cs_on; put_byte(8'h84, 0);
    for (int i = 0; i < 4; i++) put_byte(8'h11, 0);
    put_byte(8'h05, 0); put_byte(8'hAA, 0); put_byte(8'hBB, 0); cs_off;
    cs_on; put_byte(8'h03, 0); put_byte(8'h05, 0); put_byte(8'hCC, 0); put_byte(8'hDD, 0); cs_off;
    pulse_upd;
    chk("R7 ftw0 kept", 64'(ftw0), 64'h00A3D70A);
    chk("R7 phase kept", 64'(phase), 64'h2000);

    // R9: RAM command while disabled
    rc = ram_cnt;
    cs_on; put_byte(8'h0B, 0);
    put_byte(8'h05, 0); put_byte(8'h77, 0); put_byte(8'h66, 0); put_byte(8'h00, 0);
    cs_off;
    pulse_upd;
    chk("R9 no RAM write", 64'(ram_cnt), 64'(rc));
    chk("R9 phase kept", 64'(phase), 64'h2000);

    // R8/R11: RAM enabled, descending addresses, wrap
    cs_on; wr_reg(0, 40'h8000_0000); wr_reg(7, 40'h0000000007); wr_reg(8, 40'h0000000001); cs_off;
    pulse_upd;
    chk("R8 ram enable", 64'(ctl1), 64'h80000000);
    rc = ram_cnt;
    ram_stream(0, 3, 32'h00A3D70A);
    chk("R8 three words profile 0", 64'(ram_cnt - rc), 3);
    ram_stream(1, 3, 32'h03333333);
    chk("R8 wrap profile 1", 64'(ram_cnt - rc), 6);
    chk("R8 queue drained", 64'(ram_q.size()), 0);

    // R10: update rise on the same edge as the last bit
    cs_on; wr_reg(5, 40'h3ABC, 1); cs_off;
    tick(20);
    chk("R10 phase with coinciding update", 64'(phase), 64'h3ABC);

    tick(20);
    done = 1;
    summary();
    $finish;
  end
endmodule